// File: doc/BRIEF.md
# Condition Flag and Predicate Unit

This unit keeps the processor's four condition flags (Negative, Zero, Carry, Overflow) and decides, cycle by cycle, whether the instruction being presented may take effect. Each instruction carries a 4-bit condition code. The unit checks that code against the flags as they stand. The resulting execute signal gates both the result write and any flag update in the same cycle.

An instruction updates the flags only when its flag-update enable is set. The flags then come from the ALU result, carry and overflow. A compare instruction is different: the unit subtracts its second operand from its first in a subtractor of its own, updates the flags from that difference, and never asks for a result write. The ALU datapath and the register file are outside this block. The flags are exposed in the top four bits of a status word, and every other bit of that word reads zero.

Top module: `pred_flag_unit`

## Requirements
- R1: Reset (rstN low at a clock edge, synchronous) clears all four flags, so statusWord reads zero.
- R2: With instValid high, execute follows condCode against the current flags, where flag N = statusWord[31], Z = [30], C = [29], V = [28]. The codes are:
  - 0000: Z set
  - 0001: Z clear
  - 0010: C set
  - 0011: C clear
  - 0100: N set
  - 0101: N clear
  - 0110: V set
  - 0111: V clear
  - 1000: C set and Z clear
  - 1001: C clear or Z set
  - 1010: N equals V
  - 1011: N differs from V
  - 1100: Z clear and N equals V
  - 1101: Z set or N differs from V
- R3: An executing instruction with setFlags low and isCompare low leaves the flags unchanged.
- R4: An executing instruction with setFlags high and isCompare low loads the flags at the next edge. N comes from aluResult[DATA_W-1], Z is set when aluResult is zero, C comes from aluCarry and V from aluOverflow.
- R5: An executing compare (isCompare high) loads the flags from opA minus opB at the next edge, whatever setFlags says. N and Z come from the difference, C is set when no borrow occurs (opA >= opB unsigned), and V is set on signed overflow. resultWrite stays low.
- R6: A suppressed instruction (instValid high, condition false) neither updates the flags nor raises resultWrite, even when setFlags or isCompare is high.
- R7: execute and resultWrite respond combinationally in the cycle the instruction is presented. resultWrite equals execute for every non-compare instruction.
- R8: Code 1110 always executes; code 1111 never executes.
- R9: With instValid low, execute and resultWrite are low and the flags do not change.
- R10: statusWord bits below the flag field always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| instValid | input | 1 | An instruction is presented this cycle |
| condCode | input | 4 | Condition code of the instruction |
| setFlags | input | 1 | Flag-update enable of the instruction |
| isCompare | input | 1 | Instruction is a compare (subtract, flags only) |
| opA | input | DATA_W | First compare operand |
| opB | input | DATA_W | Second compare operand |
| aluResult | input | DATA_W | ALU result of a non-compare instruction |
| aluCarry | input | 1 | ALU carry out |
| aluOverflow | input | 1 | ALU signed overflow |
| execute | output | 1 | Instruction passes its condition |
| resultWrite | output | 1 | Result may be written to the destination |
| statusWord | output | STATUS_W | Flags in bits [STATUS_W-1:STATUS_W-4] as N,Z,C,V; rest zero |

## Verification
execute and resultWrite are combinational, so they are due in the same cycle the instruction is driven. The bench drives inputs just after a falling edge and samples these outputs 1 ns later, before the next rising edge. A flag change is due at the first rising edge after the instruction, so flags are read at the following falling edge, once the instruction has been removed. Each table vector first loads known flags through a flag-setting instruction and checks them. It then presents the code under test and compares execute against the hand-written expectation.

// File: rtl/pred_flag_pkg.sv
package pred_flag_pkg;

  typedef enum logic [3:0] {
    CC_EQ = 4'b0000,
    CC_NE = 4'b0001,
    CC_CS = 4'b0010,
    CC_CC = 4'b0011,
    CC_MI = 4'b0100,
    CC_PL = 4'b0101,
    CC_VS = 4'b0110,
    CC_VC = 4'b0111,
    CC_HI = 4'b1000,
    CC_LS = 4'b1001,
    CC_GE = 4'b1010,
    CC_LT = 4'b1011,
    CC_GT = 4'b1100,
    CC_LE = 4'b1101,
    CC_AL = 4'b1110,
    CC_NV = 4'b1111
  } condCode_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef struct packed {
    logic flagLoad;
    logic cmpSelect;
    logic writeResult;
  } flagStrobe_t;

  localparam int FLAG_COUNT = 4;

endpackage

// File: rtl/pred_flag_ctrl.sv
module pred_flag_ctrl
  import pred_flag_pkg::*;
(
  input  logic        instValid,
  input  logic [3:0]  condCode,
  input  logic        setFlags,
  input  logic        isCompare,
  input  nzcv_t       flagsNow,
  output logic        execute,
  output flagStrobe_t strobe
);

  function automatic logic condPass(input condCode_e code, input nzcv_t f);
    logic pass;
    case (code)
      CC_EQ:   pass = f.z;
      CC_NE:   pass = !f.z;
      CC_CS:   pass = f.c;
      CC_CC:   pass = !f.c;
      CC_MI:   pass = f.n;
      CC_PL:   pass = !f.n;
      CC_VS:   pass = f.v;
      CC_VC:   pass = !f.v;
      CC_HI:   pass = f.c && !f.z;
      CC_LS:   pass = !f.c || f.z;
      CC_GE:   pass = (f.n == f.v);
      CC_LT:   pass = (f.n != f.v);
      CC_GT:   pass = !f.z && (f.n == f.v);
      CC_LE:   pass = f.z || (f.n != f.v);
      CC_AL:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
    return pass;
  endfunction

  logic passNow;

  always_comb begin
    passNow            = condPass(condCode_e'(condCode), flagsNow);
    execute            = instValid && passNow;
    strobe.flagLoad    = execute && (setFlags || isCompare);
    strobe.cmpSelect   = isCompare;
    strobe.writeResult = execute && !isCompare;
  end

endmodule

// File: rtl/pred_flag_dp.sv
module pred_flag_dp
  import pred_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  flagStrobe_t         strobe,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [DATA_W-1:0]   aluResult,
  input  logic                aluCarry,
  input  logic                aluOverflow,
  output nzcv_t               flagsQ,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int MSB    = DATA_W - 1;
  localparam int PAD_W  = STATUS_W - FLAG_COUNT;

  logic [DATA_W:0] subWide;
  nzcv_t           cmpFlags;
  nzcv_t           aluFlags;
  nzcv_t           nextFlags;

  always_comb begin
    subWide    = {1'b0, opA} + {1'b0, ~opB} + (DATA_W+1)'(1);
    cmpFlags.n = subWide[MSB];
    cmpFlags.z = (subWide[MSB:0] == '0);
    cmpFlags.c = subWide[DATA_W];
    cmpFlags.v = (opA[MSB] ^ opB[MSB]) & (subWide[MSB] ^ opA[MSB]);

    aluFlags.n = aluResult[MSB];
    aluFlags.z = (aluResult == '0);
    aluFlags.c = aluCarry;
    aluFlags.v = aluOverflow;

    nextFlags  = strobe.cmpSelect ? cmpFlags : aluFlags;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
    end else if (strobe.flagLoad) begin
      flagsQ <= nextFlags;
    end
  end

  generate
    if (PAD_W > 0) begin : gPad
      assign statusWord = {flagsQ, {PAD_W{1'b0}}};
    end else begin : gNoPad
      assign statusWord = flagsQ;
    end
  endgenerate

endmodule

// File: rtl/pred_flag_unit.sv
module pred_flag_unit
  import pred_flag_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [3:0]          condCode,
  input  logic                setFlags,
  input  logic                isCompare,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [DATA_W-1:0]   aluResult,
  input  logic                aluCarry,
  input  logic                aluOverflow,
  output logic                execute,
  output logic                resultWrite,
  output logic [STATUS_W-1:0] statusWord
);

  flagStrobe_t strobe;
  nzcv_t       flagsQ;

  pred_flag_ctrl ctrlInst (
    .instValid (instValid),
    .condCode  (condCode),
    .setFlags  (setFlags),
    .isCompare (isCompare),
    .flagsNow  (flagsQ),
    .execute   (execute),
    .strobe    (strobe)
  );

  pred_flag_dp #(
    .DATA_W   (DATA_W),
    .STATUS_W (STATUS_W)
  ) dpInst (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .opA         (opA),
    .opB         (opB),
    .aluResult   (aluResult),
    .aluCarry    (aluCarry),
    .aluOverflow (aluOverflow),
    .flagsQ      (flagsQ),
    .statusWord  (statusWord)
  );

  assign resultWrite = strobe.writeResult;

endmodule

// File: rtl/pred_flag_unit_chk.sv
module pred_flag_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int STATUS_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                instValid,
  input logic [3:0]          condCode,
  input logic                setFlags,
  input logic                isCompare,
  input logic [DATA_W-1:0]   opA,
  input logic [DATA_W-1:0]   opB,
  input logic [DATA_W-1:0]   aluResult,
  input logic                aluCarry,
  input logic                aluOverflow,
  input logic                execute,
  input logic                resultWrite,
  input logic [STATUS_W-1:0] statusWord
);

  localparam int TOP = STATUS_W - 1;

  logic inRstQ;
  always_ff @(posedge clk) inRstQ <= !rstN;

  always @(negedge clk) begin
    if (inRstQ) begin
      assert_reset_clear_R1: assert (statusWord == '0);
    end
  end

  assert_never_and_always_R8: assert property (@(posedge clk) disable iff (!rstN)
    instValid && (condCode == 4'hF || condCode == 4'hE) |-> (execute == (condCode == 4'hE)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(instValid && execute && (setFlags || isCompare)) |=> $stable(statusWord));

  assert_flag_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    instValid && execute && setFlags && !isCompare |=>
      statusWord[TOP -: 4] == {$past(aluResult[DATA_W-1]), ($past(aluResult) == '0),
                               $past(aluCarry), $past(aluOverflow)});

  assert_cmp_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    instValid && execute && isCompare |=>
      statusWord[TOP-2] == ($past(opA) >= $past(opB)) && statusWord[TOP-1] == ($past(opA) == $past(opB)));

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    isCompare |-> !resultWrite);

  assert_suppress_R6: assert property (@(posedge clk) disable iff (!rstN)
    instValid && !execute |-> !resultWrite);

  assert_write_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    !isCompare |-> (resultWrite == execute));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !execute && !resultWrite);

  assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[TOP-4:0] == '0);

endmodule

bind pred_flag_unit pred_flag_unit_chk #(
  .DATA_W   (DATA_W),
  .STATUS_W (STATUS_W)
) chkInst (
  .clk         (clk),
  .rstN        (rstN),
  .instValid   (instValid),
  .condCode    (condCode),
  .setFlags    (setFlags),
  .isCompare   (isCompare),
  .opA         (opA),
  .opB         (opB),
  .aluResult   (aluResult),
  .aluCarry    (aluCarry),
  .aluOverflow (aluOverflow),
  .execute     (execute),
  .resultWrite (resultWrite),
  .statusWord  (statusWord)
);

// File: tb/pred_flag_unit_test.sv
`timescale 1ns/1ps
module pred_flag_unit_test;

  localparam int DW = 32;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instValid = 1'b0;
  logic [3:0]    condCode = 4'hE;
  logic          setFlags = 1'b0;
  logic          isCompare = 1'b0;
  logic [DW-1:0] opA = '0;
  logic [DW-1:0] opB = '0;
  logic [DW-1:0] aluResult = '0;
  logic          aluCarry = 1'b0;
  logic          aluOverflow = 1'b0;
  logic          execute;
  logic          resultWrite;
  logic [SW-1:0] statusWord;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  pred_flag_unit #(.DATA_W(DW), .STATUS_W(SW)) uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .condCode(condCode),
    .setFlags(setFlags), .isCompare(isCompare), .opA(opA), .opB(opB),
    .aluResult(aluResult), .aluCarry(aluCarry), .aluOverflow(aluOverflow),
    .execute(execute), .resultWrite(resultWrite), .statusWord(statusWord)
  );

  // Entry: {N,Z,C,V flags to load, condition code, expected execute}
  localparam logic [8:0] VEC_TABLE [0:23] = '{
    {4'b0100, 4'b0000, 1'b1}, {4'b0000, 4'b0000, 1'b0},
    {4'b0100, 4'b0001, 1'b0}, {4'b0000, 4'b0001, 1'b1},
    {4'b0010, 4'b0010, 1'b1}, {4'b0000, 4'b0011, 1'b1},
    {4'b1000, 4'b0100, 1'b1}, {4'b1000, 4'b0101, 1'b0},
    {4'b0001, 4'b0110, 1'b1}, {4'b0001, 4'b0111, 1'b0},
    {4'b0010, 4'b1000, 1'b1}, {4'b0110, 4'b1000, 1'b0},
    {4'b0110, 4'b1001, 1'b1}, {4'b1001, 4'b1010, 1'b1},
    {4'b1000, 4'b1010, 1'b0}, {4'b1000, 4'b1011, 1'b1},
    {4'b0000, 4'b1100, 1'b1}, {4'b0100, 4'b1100, 1'b0},
    {4'b0100, 4'b1101, 1'b1}, {4'b0001, 4'b1101, 1'b1},
    {4'b0000, 4'b1101, 1'b0}, {4'b0000, 4'b1110, 1'b1},
    {4'b1011, 4'b1111, 1'b0}, {4'b0011, 4'b0011, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    instValid = 1'b0; setFlags = 1'b0; isCompare = 1'b0; condCode = 4'hE;
  endtask

  // Load flags through a flag-setting always-execute instruction
  task automatic loadFlags(input logic [3:0] nzcv);
    @(negedge clk);
    instValid = 1'b1; condCode = 4'hE; setFlags = 1'b1; isCompare = 1'b0;
    aluResult = nzcv[3] ? 32'h8000_0000 : (nzcv[2] ? 32'h0 : 32'h0000_0001);
    aluCarry = nzcv[1]; aluOverflow = nzcv[0];
    @(negedge clk);
    idle();
  endtask

  task automatic doCompare(input logic [31:0] a, input logic [31:0] b, input logic [3:0] expFlags);
    @(negedge clk);
    instValid = 1'b1; condCode = 4'hE; setFlags = 1'b0; isCompare = 1'b1; opA = a; opB = b;
    #1;
    check(execute == 1'b1 && resultWrite == 1'b0, "R5 compare write", {30'd0, execute, resultWrite}, 32'd2);
    @(negedge clk);
    idle();
    check(statusWord[31:28] == expFlags, "R5 compare flags", {28'd0, statusWord[31:28]}, {28'd0, expFlags});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // Reset: try a flag-setting instruction while reset is held
    instValid = 1'b1; setFlags = 1'b1; aluResult = 32'h8000_0000; aluCarry = 1'b1; aluOverflow = 1'b1;
    repeat (3) @(negedge clk);
    check(statusWord == 32'h0, "R1 reset clears flags", statusWord, 32'h0);
    idle();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(statusWord == 32'h0, "R1 flags after reset release", statusWord, 32'h0);

    // Table walk: R2, R8
    for (int i = 0; i < 24; i++) begin
      logic [3:0] fl;
      logic [3:0] cc;
      logic       ex;
      fl = VEC_TABLE[i][8:5];
      cc = VEC_TABLE[i][4:1];
      ex = VEC_TABLE[i][0];
      loadFlags(fl);
      check(statusWord[31:28] == fl, "R4 flag load", {28'd0, statusWord[31:28]}, {28'd0, fl});
      check(statusWord[27:0] == 28'd0, "R10 low bits zero", statusWord, {fl, 28'd0});
      @(negedge clk);
      instValid = 1'b1; condCode = cc; setFlags = 1'b0; isCompare = 1'b0;
      #1;
      check(execute == ex, (cc >= 4'hE) ? "R8 always/never" : "R2 condition", {31'd0, execute}, {31'd0, ex});
      check(resultWrite == ex, "R7 write follows execute", {31'd0, resultWrite}, {31'd0, ex});
      @(negedge clk);
      idle();
      check(statusWord[31:28] == fl, "R3 plain op keeps flags", {28'd0, statusWord[31:28]}, {28'd0, fl});
    end

    // R3: plain op whose result would set Z and C if flags were written
    loadFlags(4'b1001);
    @(negedge clk);
    instValid = 1'b1; condCode = 4'hE; setFlags = 1'b0; aluResult = 32'h0; aluCarry = 1'b1; aluOverflow = 1'b0;
    @(negedge clk);
    idle();
    check(statusWord[31:28] == 4'b1001, "R3 no-update op", {28'd0, statusWord[31:28]}, 32'h9);

    // R5: compare cases
    doCompare(32'd5, 32'd5, 4'b0110);
    doCompare(32'd3, 32'd5, 4'b1000);
    @(negedge clk);
    instValid = 1'b1; condCode = 4'b1011; #1;
    check(execute == 1'b1, "R2 LT after compare 3 vs 5", {31'd0, execute}, 32'd1);
    condCode = 4'b1010; #1;
    check(execute == 1'b0, "R2 GE after compare 3 vs 5", {31'd0, execute}, 32'd0);
    idle();
    doCompare(32'h8000_0000, 32'h0000_0001, 4'b0011);
    doCompare(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b1001);
    doCompare(32'h0000_0007, 32'hFFFF_FFFE, 4'b0000);

    // R6: suppressed flag-setting instruction and suppressed compare
    loadFlags(4'b0100);
    @(negedge clk);
    instValid = 1'b1; condCode = 4'b0001; setFlags = 1'b1; aluResult = 32'h8000_0000; aluCarry = 1'b1; aluOverflow = 1'b1;
    #1;
    check(execute == 1'b0 && resultWrite == 1'b0, "R6 suppressed signals", {30'd0, execute, resultWrite}, 32'd0);
    @(negedge clk);
    setFlags = 1'b0; isCompare = 1'b1; opA = 32'd1; opB = 32'd2;
    @(negedge clk);
    idle();
    check(statusWord[31:28] == 4'b0100, "R6 suppressed keeps flags", {28'd0, statusWord[31:28]}, 32'h4);

    // R8: never code with flag-setting request
    @(negedge clk);
    instValid = 1'b1; condCode = 4'hF; setFlags = 1'b1; aluResult = 32'h1; aluCarry = 1'b1;
    #1;
    check(execute == 1'b0, "R8 never executes", {31'd0, execute}, 32'd0);
    @(negedge clk);
    idle();
    check(statusWord[31:28] == 4'b0100, "R8 never keeps flags", {28'd0, statusWord[31:28]}, 32'h4);

    // R9: no valid instruction
    @(negedge clk);
    instValid = 1'b0; condCode = 4'hE; setFlags = 1'b1; isCompare = 1'b0; aluResult = 32'h8000_0000;
    #1;
    check(execute == 1'b0 && resultWrite == 1'b0, "R9 idle outputs", {30'd0, execute, resultWrite}, 32'd0);
    @(negedge clk);
    isCompare = 1'b1; setFlags = 1'b0; opA = 32'd9; opB = 32'd9;
    @(negedge clk);
    idle();
    check(statusWord[31:28] == 4'b0100, "R9 idle keeps flags", {28'd0, statusWord[31:28]}, 32'h4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule